// File: doc/BRIEF.md
# Predicated Lockstep Lane Array

A row of identical lanes that execute one broadcast instruction per clock, all together. Each lane owns a 16-bit accumulator, a one-bit selection marker and a small private bank of vector registers. A controller presents an opcode and an immediate every cycle. Every instruction that touches an accumulator or a bank entry does so only in lanes whose marker is set. Some instructions narrow or flip the markers themselves, so a short program can carve out periodic subsets of lanes without loading any data.

A host port writes and reads any bank entry by lane number and vector number. The block drives the accumulators, the markers and an any-selected flag on its outputs. Each output shows the state after the last instruction.

Top module: `lane_array`

## Requirements
- R1: After reset every marker is set, every accumulator and every bank entry is 0, and `any_sel` is 1.
- R2: Opcode 1 (index) loads each selected lane's accumulator with that lane's number (lane 0 is bit 0 of `lane_sel`, bits 15:0 of `lane_acc`).
- R3: Opcode 2 replaces each selected accumulator with its bitwise AND with `op_imm`.
- R4: Opcode 3 (keep-if-different) clears the marker of each selected lane whose accumulator equals `op_imm`. Lanes already cleared stay cleared.
- R5: Opcode 4 writes `op_imm` into the accumulator of each selected lane.
- R6: Opcode 5 inverts the marker of every lane.
- R7: Opcode 6 copies each selected accumulator into bank vector `op_imm[1:0]` of that lane. Bank entries of deselected lanes keep their contents.
- R8: Opcode 7 copies bank vector `op_imm[1:0]` into the accumulator of each selected lane.
- R9: Opcode 8 sets every marker.
- R10: `any_sel` is the OR of all markers and reflects the instruction of the previous clock.
- R11: No instruction changes the accumulator of a deselected lane.
- R12: Opcode 0 and the codes 9 to 15 change nothing. A host write with `host_we` high stores `host_wdata` at (`host_lane`, `host_vec`). `host_rdata` shows that entry combinationally.
- R13: Starting with all lanes selected, the program store-to-vector 0, index, AND 3, keep-if-different 0, store 0xFFFF, complement, load-from-vector 0 keeps the value of every fourth lane (lanes 0, 4, 8, 12) and turns the others into 0xFFFF. After it, `lane_sel` is 0x1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 4 | Broadcast opcode, one instruction per cycle |
| op_imm | input | 16 | Broadcast immediate / vector number |
| host_we | input | 1 | Host bank write strobe |
| host_lane | input | 4 | Host lane number |
| host_vec | input | 2 | Host vector number |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Bank entry at host_lane/host_vec |
| lane_acc | output | 256 | All accumulators, lane n at bits 16n+15:16n |
| lane_sel | output | 16 | All markers, lane n at bit n |
| any_sel | output | 1 | High while at least one marker is set |

## Verification
The bench runs the every-fourth-lane program step by step. A design that predicated the complement, or ran keep-if-different with the opposite sense, would restore the wrong lanes. It then deselects every lane and issues a store and a store-to-vector. A design that ignored the markers would change accumulators or bank contents that the host port then shows. It also checks that `any_sel` drops to 0 and comes back only through complement or select-all. Undefined opcodes must leave all state unchanged. An index and AND pair must leave only odd lanes selected, which catches a lane numbering that is off by one or reversed.

// File: rtl/lane_pkg.sv
package lane_pkg;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_INDEX  = 4'd1,
        OP_ANDI   = 4'd2,
        OP_KEEPNE = 4'd3,
        OP_STORE  = 4'd4,
        OP_CMPL   = 4'd5,
        OP_VST    = 4'd6,
        OP_VLD    = 4'd7,
        OP_SELALL = 4'd8
    } lane_op_e;

    typedef struct packed {
        logic idx;
        logic andi;
        logic keepne;
        logic store;
        logic cmpl;
        logic vst;
        logic vld;
        logic all;
    } lane_ctrl_t;

endpackage

// File: rtl/op_decode.sv
module op_decode
    import lane_pkg::*;
(
    input  logic [3:0] code,
    output lane_ctrl_t ctrl
);
    always_comb begin
        ctrl = '0;
        case (code)
            OP_INDEX:  ctrl.idx    = 1'b1;
            OP_ANDI:   ctrl.andi   = 1'b1;
            OP_KEEPNE: ctrl.keepne = 1'b1;
            OP_STORE:  ctrl.store  = 1'b1;
            OP_CMPL:   ctrl.cmpl   = 1'b1;
            OP_VST:    ctrl.vst    = 1'b1;
            OP_VLD:    ctrl.vld    = 1'b1;
            OP_SELALL: ctrl.all    = 1'b1;
            default:   ctrl        = '0;
        endcase
    end
endmodule

// File: rtl/lane_cell.sv
module lane_cell
    import lane_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int NUM_VEC = 4,
    parameter int LANE_ID = 0,
    localparam int VW     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  lane_ctrl_t                     ctrl,
    input  logic [WORD_W-1:0]              imm,
    input  logic                           host_we,
    input  logic [VW-1:0]                  host_vec,
    input  logic [WORD_W-1:0]              host_wdata,
    output logic [WORD_W-1:0]              acc_o,
    output logic                           sel_o,
    output logic [NUM_VEC-1:0][WORD_W-1:0] bank_o
);
    localparam logic [WORD_W-1:0] ID_VAL = WORD_W'(LANE_ID);

    typedef struct packed {
        logic [WORD_W-1:0]              acc;
        logic                           sel;
        logic [NUM_VEC-1:0][WORD_W-1:0] bank;
    } cell_st_t;

    cell_st_t      st_d, st_q;
    logic [VW-1:0] vsel_d;

    always_comb begin
        st_d   = st_q;
        vsel_d = imm[VW-1:0];
        if (host_we) begin
            st_d.bank[host_vec] = host_wdata;
        end
        if (st_q.sel) begin
            if (ctrl.idx)    st_d.acc = ID_VAL;
            if (ctrl.andi)   st_d.acc = st_q.acc & imm;
            if (ctrl.store)  st_d.acc = imm;
            if (ctrl.vld)    st_d.acc = st_q.bank[vsel_d];
            if (ctrl.vst)    st_d.bank[vsel_d] = st_q.acc;
            if (ctrl.keepne && (st_q.acc == imm)) st_d.sel = 1'b0;
        end
        if (ctrl.cmpl) st_d.sel = ~st_q.sel;
        if (ctrl.all)  st_d.sel = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.acc  <= '0;
            st_q.sel  <= 1'b1;
            st_q.bank <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o  = st_q.acc;
    assign sel_o  = st_q.sel;
    assign bank_o = st_q.bank;

    // R6
    cmpl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.cmpl |=> (sel_o != $past(sel_o)));

    // R11
    idle_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_o |=> $stable(acc_o));

    // R4
    stay_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_o && !ctrl.cmpl && !ctrl.all) |=> !sel_o);

    // R5
    store_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o && ctrl.store) |=> (acc_o == $past(imm)));

    // R2
    index_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o && ctrl.idx) |=> (acc_o == ID_VAL));
endmodule

// File: rtl/host_mux.sv
module host_mux #(
    parameter int NUM_LANES = 16,
    parameter int NUM_VEC   = 4,
    parameter int WORD_W    = 16,
    localparam int LW       = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
    localparam int VW       = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic [NUM_LANES-1:0][NUM_VEC-1:0][WORD_W-1:0] banks,
    input  logic [LW-1:0]                                  lane,
    input  logic [VW-1:0]                                  vec,
    output logic [WORD_W-1:0]                              rdata
);
    always_comb begin
        rdata = banks[lane][vec];
    end
endmodule

// File: rtl/lane_array.sv
module lane_array
    import lane_pkg::*;
#(
    parameter int NUM_LANES = 16,
    parameter int WORD_W    = 16,
    parameter int NUM_VEC   = 4,
    localparam int LW       = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
    localparam int VW       = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [3:0]                    op_code,
    input  logic [WORD_W-1:0]             op_imm,
    input  logic                          host_we,
    input  logic [LW-1:0]                 host_lane,
    input  logic [VW-1:0]                 host_vec,
    input  logic [WORD_W-1:0]             host_wdata,
    output logic [WORD_W-1:0]             host_rdata,
    output logic [NUM_LANES*WORD_W-1:0]   lane_acc,
    output logic [NUM_LANES-1:0]          lane_sel,
    output logic                          any_sel
);
    lane_ctrl_t                                     ctrl;
    logic [NUM_LANES-1:0][WORD_W-1:0]               accs;
    logic [NUM_LANES-1:0][NUM_VEC-1:0][WORD_W-1:0]  banks;

    op_decode u_dec (
        .code (op_code),
        .ctrl (ctrl)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic lane_we;
        assign lane_we = host_we && (host_lane == LW'(g));
        lane_cell #(
            .WORD_W  (WORD_W),
            .NUM_VEC (NUM_VEC),
            .LANE_ID (g)
        ) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl       (ctrl),
            .imm        (op_imm),
            .host_we    (lane_we),
            .host_vec   (host_vec),
            .host_wdata (host_wdata),
            .acc_o      (accs[g]),
            .sel_o      (lane_sel[g]),
            .bank_o     (banks[g])
        );
    end

    host_mux #(
        .NUM_LANES (NUM_LANES),
        .NUM_VEC   (NUM_VEC),
        .WORD_W    (WORD_W)
    ) u_rd (
        .banks (banks),
        .lane  (host_lane),
        .vec   (host_vec),
        .rdata (host_rdata)
    );

    assign lane_acc = accs;
    assign any_sel  = |lane_sel;

    // R9
    selall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_SELALL) |=> (any_sel && (lane_sel == {NUM_LANES{1'b1}})));

    // R10
    none_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_sel && (op_code != OP_CMPL) && (op_code != OP_SELALL)) |=> !any_sel);
endmodule

// File: tb/tb_lane_array.sv
module tb_lane_array;
    localparam int CLK_P = 10;
    localparam int NL    = 16;
    localparam int W     = 16;
    localparam int NV    = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      op_code = '0;
    logic [W-1:0]    op_imm = '0;
    logic            host_we = 1'b0;
    logic [3:0]      host_lane = '0;
    logic [1:0]      host_vec = '0;
    logic [W-1:0]    host_wdata = '0;
    logic [W-1:0]    host_rdata;
    logic [NL*W-1:0] lane_acc;
    logic [NL-1:0]   lane_sel;
    logic            any_sel;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0]  m_acc [NL];
    logic [NL-1:0] m_sel;
    logic [W-1:0]  m_bank [NL][NV];
    logic [W-1:0]  series [NL];

    logic [NL*W-1:0] q_acc [$];
    logic [NL-1:0]   q_sel [$];
    string           q_req [$];

    always #(CLK_P/2) clk = ~clk;

    lane_array dut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_imm(op_imm),
        .host_we(host_we), .host_lane(host_lane), .host_vec(host_vec),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .lane_acc(lane_acc), .lane_sel(lane_sel), .any_sel(any_sel)
    );

    function automatic logic [NL*W-1:0] pack_acc();
        logic [NL*W-1:0] v;
        for (int i = 0; i < NL; i++) v[i*W +: W] = m_acc[i];
        return v;
    endfunction

    task automatic push_exp(string req);
        q_acc.push_back(pack_acc());
        q_sel.push_back(m_sel);
        q_req.push_back(req);
    endtask

    task automatic model_op(logic [3:0] code, logic [W-1:0] imm);
        for (int i = 0; i < NL; i++) begin
            case (code)
                4'd1: if (m_sel[i]) m_acc[i] = W'(i);
                4'd2: if (m_sel[i]) m_acc[i] = m_acc[i] & imm;
                4'd3: if (m_sel[i] && m_acc[i] == imm) m_sel[i] = 1'b0;
                4'd4: if (m_sel[i]) m_acc[i] = imm;
                4'd5: m_sel[i] = ~m_sel[i];
                4'd6: if (m_sel[i]) m_bank[i][imm[1:0]] = m_acc[i];
                4'd7: if (m_sel[i]) m_acc[i] = m_bank[i][imm[1:0]];
                4'd8: m_sel[i] = 1'b1;
                default: ;
            endcase
        end
    endtask

    task automatic issue(logic [3:0] code, logic [W-1:0] imm, string req);
        @(negedge clk);
        host_we = 1'b0;
        op_code = code;
        op_imm  = imm;
        model_op(code, imm);
        push_exp(req);
    endtask

    task automatic host_write(int lane, int vec, logic [W-1:0] d);
        @(negedge clk);
        op_code    = 4'd0;
        host_we    = 1'b1;
        host_lane  = 4'(lane);
        host_vec   = 2'(vec);
        host_wdata = d;
        m_bank[lane][vec] = d;
        push_exp("R12");
    endtask

    task automatic drain();
        @(negedge clk);
        op_code = 4'd0;
        host_we = 1'b0;
        @(posedge clk);
        #3;
    endtask

    task automatic chk(string req, logic [NL*W-1:0] act, logic [NL*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_bank(string req, int lane, int vec);
        host_lane = 4'(lane);
        host_vec  = 2'(vec);
        #1;
        chk(req, {{(NL-1)*W{1'b0}}, host_rdata}, {{(NL-1)*W{1'b0}}, m_bank[lane][vec]});
    endtask

    // Monitor: one expected item per clock, sampled after the edge settles
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_req.size() > 0) begin
                logic [NL*W-1:0] ea;
                logic [NL-1:0]   es;
                string           r;
                ea = q_acc.pop_front();
                es = q_sel.pop_front();
                r  = q_req.pop_front();
                chk({r, " acc"}, lane_acc, ea);
                chk({r, " sel"}, {{(NL*W-NL){1'b0}}, lane_sel}, {{(NL*W-NL){1'b0}}, es});
                chk({r, " R10 any"}, {{(NL*W-1){1'b0}}, any_sel}, {{(NL*W-1){1'b0}}, |es});
            end
        end
    end

    initial begin
        #(CLK_P * 50000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [NL*W-1:0] hand;
        series = '{16'd1, 16'd3, 16'd1, 16'd1, 16'd4, 16'd2, 16'd2, 16'd2,
                   16'd3, 16'd1, 16'd1, 16'd1, 16'd9, 16'd5, 16'd6, 16'd7};
        for (int i = 0; i < NL; i++) begin
            m_acc[i] = '0;
            for (int v = 0; v < NV; v++) m_bank[i][v] = '0;
        end
        m_sel = '1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 acc", lane_acc, '0);
        chk("R1 sel", {{(NL*W-NL){1'b0}}, lane_sel}, {{(NL*W-NL){1'b0}}, {NL{1'b1}}});
        chk("R1 any", {{(NL*W-1){1'b0}}, any_sel}, {{(NL*W-1){1'b0}}, 1'b1});
        chk_bank("R1 bank", 9, 2);

        // R12 host writes and reads
        for (int i = 0; i < NL; i++) host_write(i, 1, series[i]);
        drain();
        chk_bank("R12 read", 0, 1);
        chk_bank("R12 read", 12, 1);
        chk_bank("R12 read", 15, 1);

        // R8 load series into accumulators
        issue(4'd7, 16'd1, "R8");

        // R13 every-fourth-lane program
        issue(4'd6, 16'd0, "R7");
        issue(4'd1, 16'd0, "R2");
        issue(4'd2, 16'd3, "R3");
        issue(4'd3, 16'd0, "R4");
        issue(4'd4, 16'hFFFF, "R5");
        issue(4'd5, 16'd0, "R6");
        issue(4'd7, 16'd0, "R8");
        drain();
        for (int i = 0; i < NL; i++)
            hand[i*W +: W] = (i % 4 == 0) ? series[i] : 16'hFFFF;
        chk("R13 acc", lane_acc, hand);
        chk("R13 sel", {{(NL*W-NL){1'b0}}, lane_sel}, {{(NL*W-NL){1'b0}}, 16'h1111});

        // R10 / R11 / R7: deselect everything, then try to modify
        issue(4'd4, 16'd7, "R5");
        issue(4'd3, 16'd7, "R4");
        issue(4'd4, 16'h0055, "R11");
        issue(4'd6, 16'd2, "R7");
        issue(4'd1, 16'd0, "R11");
        drain();
        chk("R10 none", {{(NL*W-1){1'b0}}, any_sel}, '0);
        chk_bank("R7 masked", 0, 2);
        chk_bank("R7 masked", 5, 2);

        // R6 complement brings all back; R2/R3/R4/R9
        issue(4'd5, 16'd0, "R6");
        issue(4'd1, 16'd0, "R2");
        issue(4'd2, 16'd1, "R3");
        issue(4'd3, 16'd0, "R4");
        drain();
        chk("R4 odd", {{(NL*W-NL){1'b0}}, lane_sel}, {{(NL*W-NL){1'b0}}, 16'hAAAA});
        issue(4'd8, 16'd0, "R9");
        // R12 undefined and idle codes
        issue(4'd15, 16'h1234, "R12");
        issue(4'd9, 16'h0000, "R12");
        issue(4'd0, 16'hFFFF, "R12");
        issue(4'd6, 16'd3, "R7");
        drain();
        chk_bank("R7 store", 7, 3);
        chk_bank("R7 store", 6, 3);
        chk_bank("R7 keep", 4, 0);

        repeat (3) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule